// File: doc/BRIEF.md
# Spill Synchronization Bypass Gate

This block decides when a beam spill may start and produces the triggers that follow from that decision. A start request comes from one of two places: the accelerator's gated machine-start level, or, when the internal-clock select is set, a slow tick made by dividing the system clock. The internal tick lets the detectors run without beam. A rising edge of the selected source is a candidate start. The candidate is validated only when four subsystems all report ready. These are the DAQ (its idle signal), the RF system, the target and the control/monitoring system. Each of the four ready inputs has its own bypass bit that forces it true. Any bypass bit that is set raises a warning flag, so that software can warn the operator when a run starts.

A validated start pulses the target and RF triggers for one cycle. A programmable delay follows, and then the start-of-spill trigger pulses. After it, a particle-trigger window stays open for a programmable number of cycles. A validated start may arrive while the previous spill's busy is still high. That start is suppressed, and a sticky overlap flag is set that only reset clears.

The sequencer is a five-state machine:
- IDLE waits for a candidate start.
- ARM drives the target and RF triggers.
- DELAY counts the start-of-spill delay.
- FIRE drives the start-of-spill trigger.
- WINDOW holds the particle window open.

Its transitions are:
- `accept`: IDLE to ARM, on a ready start with busy low.
- `arm_done`: ARM to DELAY.
- `delay_done`: DELAY to FIRE.
- `fire_done`: FIRE to WINDOW.
- `window_done`: WINDOW to IDLE.

A start that is not ready, or that is blocked by busy, leaves the machine in IDLE.

Top module: `spill_sync_gate`

## Requirements
- R1: A candidate start is accepted only when each of the four ready inputs is high or bypassed; otherwise no trigger is produced.
- R2: Bypass bit 0 forces DAQ idle, bit 1 forces RF ready, bit 2 forces target ready, and bit 3 forces control ready.
- R3: `bypass_warn` is high whenever any bypass bit is set and low when none is.
- R4: An accepted start raises `target_trig` and `rf_trig` together for exactly one cycle, in the cycle after the clock edge that sees the source rise.
- R5: `sos_trig` is a one-cycle pulse that begins `delay_cycles`+1 cycles after the target pulse begins (`delay_cycles` ≥ 1).
- R6: `particle_window` is high for exactly `window_cycles` cycles (≥ 1), starting in the cycle after the `sos_trig` pulse.
- R7: Start edges that arrive while a sequence is in progress are ignored and do not alter its timing.
- R8: A start that is ready but arrives while `prev_spill_busy` is high produces no trigger and sets `overlap_seen`, which stays high until reset; `overlap_seen` is never set otherwise.
- R9: With `internal_clk_sel` high, `machine_start` is ignored and a start occurs once every `TICK_DIV` cycles.
- R10: During and right after reset, all trigger outputs, the window and `overlap_seen` are low.
- R11: Only a rising edge starts a sequence; holding the source high produces a single sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| daq_idle | input | 1 | DAQ ready (idle) |
| rf_ready | input | 1 | RF system ready |
| target_ready | input | 1 | Target system ready |
| ctrl_ready | input | 1 | Control/monitoring ready |
| bypass_mask | input | 4 | Per-input bypass bits (bit order in R2) |
| internal_clk_sel | input | 1 | Use divided internal tick instead of machine start |
| machine_start | input | 1 | Gated machine-start level |
| prev_spill_busy | input | 1 | Previous spill readout still busy |
| delay_cycles | input | CW | Start-of-spill delay in cycles |
| window_cycles | input | CW | Particle window width in cycles |
| target_trig | output | 1 | Target trigger pulse |
| rf_trig | output | 1 | RF trigger pulse |
| sos_trig | output | 1 | Start-of-spill trigger pulse |
| particle_window | output | 1 | Particle-trigger window |
| bypass_warn | output | 1 | Any bypass active |
| overlap_seen | output | 1 | Sticky overlap flag |

## Verification
The assertions take for granted three things about the inputs:
- `delay_cycles` and `window_cycles` are at least one.
- Both stay stable while a sequence runs.
- `TICK_DIV` is at least two, so that internal ticks are single-cycle pulses.

The stimulus sets the lengths only while the sequencer is idle, and uses small nonzero values. It changes the ready, bypass and busy inputs only between sequences. It sweeps all 256 ready/bypass combinations. It re-pulses the start source inside a running sequence on purpose, to exercise R7.

// File: rtl/spill_pkg.sv
package spill_pkg;
    localparam int NUM_READY = 4;
    localparam int IDX_DAQ   = 0;
    localparam int IDX_RF    = 1;
    localparam int IDX_TGT   = 2;
    localparam int IDX_CTRL  = 3;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ARM,
        SQ_DELAY,
        SQ_FIRE,
        SQ_WINDOW
    } sq_state_t;
endpackage

// File: rtl/ready_gate.sv
module ready_gate #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ready_in,
    input  logic [N-1:0] bypass,
    output logic         all_ready,
    output logic         bypass_active
);
    logic [N-1:0] forced;

    for (genvar g = 0; g < N; g++) begin : g_force
        assign forced[g] = ready_in[g] | bypass[g];
    end

    assign all_ready     = &forced;
    assign bypass_active = |bypass;

    AST_READY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (&ready_in) |-> all_ready);  // R1
    AST_WARN_ON_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass != '0) |-> bypass_active);  // R3
endmodule

// File: rtl/tick_div.sv
module tick_div #(
    parameter int TICK_DIV = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);  // R9
endmodule

// File: rtl/spill_seq.sv
module spill_seq
    import spill_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_edge,
    input  logic          all_ready,
    input  logic          busy,
    input  logic [CW-1:0] delay_len,
    input  logic [CW-1:0] window_len,
    output logic          tgt_trig,
    output logic          rf_trig,
    output logic          sos_trig,
    output logic          win,
    output logic          overlap
);
    sq_state_t     state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          ovl_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        ovl_nx   = overlap;
        unique case (state)
            SQ_IDLE: begin
                if (start_edge && all_ready) begin
                    if (busy) ovl_nx = 1'b1;
                    else      state_nx = SQ_ARM;
                end
            end
            SQ_ARM: begin
                state_nx = SQ_DELAY;
                cnt_nx   = CW'(1);
            end
            SQ_DELAY: begin
                if (cnt >= delay_len) state_nx = SQ_FIRE;
                else                  cnt_nx   = cnt + 1'b1;
            end
            SQ_FIRE: begin
                state_nx = SQ_WINDOW;
                cnt_nx   = CW'(1);
            end
            SQ_WINDOW: begin
                if (cnt >= window_len) state_nx = SQ_IDLE;
                else                   cnt_nx   = cnt + 1'b1;
            end
            default: state_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            cnt     <= '0;
            overlap <= 1'b0;
        end else begin
            state   <= state_nx;
            cnt     <= cnt_nx;
            overlap <= ovl_nx;
        end
    end

    always_comb begin
        tgt_trig = 1'b0;
        rf_trig  = 1'b0;
        sos_trig = 1'b0;
        win      = 1'b0;
        unique case (state)
            SQ_ARM:    begin tgt_trig = 1'b1; rf_trig = 1'b1; end
            SQ_FIRE:   sos_trig = 1'b1;
            SQ_WINDOW: win = 1'b1;
            default: ;
        endcase
    end

    AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_trig |=> !tgt_trig);  // R4
    AST_SOS_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        sos_trig |=> win);  // R6
    AST_OVERLAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overlap |=> overlap);  // R8
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_edge && busy && !tgt_trig && !sos_trig && !win && state == SQ_IDLE) |=> !tgt_trig);  // R8
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        win |=> !tgt_trig);  // R7
endmodule

// File: rtl/spill_sync_gate.sv
module spill_sync_gate
    import spill_pkg::*;
#(
    parameter int TICK_DIV = 100_000_000,
    parameter int CW       = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          daq_idle,
    input  logic          rf_ready,
    input  logic          target_ready,
    input  logic          ctrl_ready,
    input  logic [3:0]    bypass_mask,
    input  logic          internal_clk_sel,
    input  logic          machine_start,
    input  logic          prev_spill_busy,
    input  logic [CW-1:0] delay_cycles,
    input  logic [CW-1:0] window_cycles,
    output logic          target_trig,
    output logic          rf_trig,
    output logic          sos_trig,
    output logic          particle_window,
    output logic          bypass_warn,
    output logic          overlap_seen
);
    logic [NUM_READY-1:0] ready_vec;
    logic                 all_ready;
    logic                 tick;
    logic                 src, src_q, start_edge;

    always_comb begin
        ready_vec           = '0;
        ready_vec[IDX_DAQ]  = daq_idle;
        ready_vec[IDX_RF]   = rf_ready;
        ready_vec[IDX_TGT]  = target_ready;
        ready_vec[IDX_CTRL] = ctrl_ready;
    end

    ready_gate #(.N(NUM_READY)) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .ready_in      (ready_vec),
        .bypass        (bypass_mask),
        .all_ready     (all_ready),
        .bypass_active (bypass_warn)
    );

    tick_div #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign src = internal_clk_sel ? tick : machine_start;

    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= src;
    end

    assign start_edge = src & ~src_q;

    spill_seq #(.CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_edge (start_edge),
        .all_ready  (all_ready),
        .busy       (prev_spill_busy),
        .delay_len  (delay_cycles),
        .window_len (window_cycles),
        .tgt_trig   (target_trig),
        .rf_trig    (rf_trig),
        .sos_trig   (sos_trig),
        .win        (particle_window),
        .overlap    (overlap_seen)
    );

    AST_HELD_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (src && src_q) |-> !start_edge);  // R11
endmodule

// File: tb/tb_spill_sync_gate.sv
module tb_spill_sync_gate;
    localparam int TDIV = 40;
    localparam int CW   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic daq_idle = 0, rf_ready = 0, target_ready = 0, ctrl_ready = 0;
    logic [3:0] bypass_mask = '0;
    logic internal_clk_sel = 0, machine_start = 0, prev_spill_busy = 0;
    logic [CW-1:0] delay_cycles = 8'd1, window_cycles = 8'd1;
    logic target_trig, rf_trig, sos_trig, particle_window, bypass_warn, overlap_seen;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    spill_sync_gate #(.TICK_DIV(TDIV), .CW(CW)) dut (.*);

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic set_ready(input logic [3:0] r);
        {ctrl_ready, target_ready, rf_ready, daq_idle} = r;
    endtask

    // Vector order {target, rf, sos, window}
    task automatic run_spill(input bit acc, input int d, input int w, input bit poke, input string req);
        @(negedge clk);
        machine_start = 1'b1;
        for (int i = 0; i < d + w + 3; i++) begin
            @(negedge clk);
            chk(req, {target_trig, rf_trig, sos_trig, particle_window},
                {acc && i == 0, acc && i == 0, acc && i == d + 1,
                 acc && i >= d + 2 && i <= d + 1 + w});
            if (poke && i == 1) machine_start = 1'b0;
            if (poke && i == 2) machine_start = 1'b1;
        end
        machine_start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset outputs", {target_trig, rf_trig, sos_trig, particle_window, overlap_seen}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after reset", {target_trig, rf_trig, sos_trig, particle_window, overlap_seen}, 0);

        // R5 R6 R11: timing sweep with all ready, source held high through the sequence
        set_ready(4'hF);
        for (int d = 1; d <= 3; d++) begin
            for (int w = 1; w <= 4; w++) begin
                delay_cycles  = CW'(d);
                window_cycles = CW'(w);
                run_spill(1'b1, d, w, 1'b0, "R5/R6/R11 timing");
            end
        end

        // R1 R2 R3: every ready/bypass combination
        delay_cycles  = 8'd1;
        window_cycles = 8'd1;
        for (int r = 0; r < 16; r++) begin
            for (int b = 0; b < 16; b++) begin
                set_ready(4'(r));
                bypass_mask = 4'(b);
                @(negedge clk);
                chk("R3 bypass_warn", bypass_warn, b != 0);
                run_spill(((r | b) & 15) == 15, 1, 1, 1'b0, "R1/R2/R4 gating");
            end
        end
        bypass_mask = '0;
        set_ready(4'hF);
        chk("R8 no false overlap", overlap_seen, 0);

        // R7: re-edge during DELAY is ignored
        delay_cycles  = 8'd3;
        window_cycles = 8'd2;
        run_spill(1'b1, 3, 2, 1'b1, "R7 re-edge ignored");

        // R8: busy suppression and stickiness
        prev_spill_busy = 1'b1;
        run_spill(1'b0, 3, 2, 1'b0, "R8 busy suppress");
        chk("R8 overlap set", overlap_seen, 1);
        prev_spill_busy = 1'b0;
        run_spill(1'b1, 3, 2, 1'b0, "R8 normal after overlap");
        chk("R8 overlap sticky", overlap_seen, 1);

        // R9: internal tick, machine_start toggled and ignored
        delay_cycles     = 8'd2;
        window_cycles    = 8'd3;
        internal_clk_sel = 1'b1;
        begin
            int npulse = 0;
            int nrf    = 0;
            for (int i = 0; i < 5 * TDIV; i++) begin
                @(negedge clk);
                if (target_trig) npulse++;
                if (rf_trig) nrf++;
                if (i % 7 == 0) machine_start = ~machine_start;
            end
            chk("R9 internal start count", npulse, 5);
            chk("R4 rf pulses match", nrf, 5);
        end
        machine_start = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule